// File: doc/BRIEF.md
# Sixteen-Entry Content-Addressable Lookup Unit

This block keeps a small table of 8-bit words, each guarded by its own valid flag, and answers "where is this key stored?" in a single registered cycle. When a lookup request arrives with a key, every valid entry is compared against that key in parallel. The block then returns an answer shaped by the requested mode. The first-hit mode gives the lowest-numbered matching slot. The all-hits mode gives a bitmap of every slot that matched, together with the number of matches.

The table is written through an independent update port that assigns a word to a slot and marks the slot valid. An invalidation port empties one chosen slot or every slot at once. Both ports may be used in the same cycle as a lookup. A lookup always sees the table as it stood before that cycle's edge, so updates never stall or corrupt a search in flight. Slots that are not valid never take part in a match, whatever bits they still hold.

Top module: `cam_lookup_unit`

## Requirements
- R1: After reset, res_valid, res_hit, res_idx, res_vec and res_count are all zero, and every slot is invalid, so a lookup of any key misses.
- R2: A write with wr_en high stores wr_data in slot wr_idx and marks it valid; a lookup issued on a later cycle finds it.
- R3: res_valid is high exactly in the cycle after a cycle with lk_valid high, and low otherwise.
- R4: With lk_mode = 0 (first-hit), a hit returns res_hit = 1, res_idx = the lowest matching valid slot, res_vec = a one-hot bitmap with only that slot's bit set (bit i for slot i), and res_count = 1.
- R5: With lk_mode = 1 (all-hits), res_vec has bit i set for every valid slot i whose word equals lk_key, res_count is the number of set bits (up to 16), and res_idx is the lowest set bit.
- R6: A miss in either mode returns res_hit = 0, res_idx = 0, res_vec = 0 and res_count = 0.
- R7: A slot that has been invalidated never matches, even though it still holds the old word.
- R8: clr_en high with clr_all low invalidates only slot clr_idx; every other slot is unaffected.
- R9: clr_en high with clr_all high invalidates every slot at one clock edge, and a lookup on the next cycle misses.
- R10: A lookup in the same cycle as a write to a slot uses the slot's contents from before the write; the new word is visible from the next cycle on.
- R11: When a write and an invalidation hit the same slot in the same cycle, the write wins: the slot ends valid and holds the new word.
- R12: In cycles with lk_valid low, res_hit, res_idx, res_vec and res_count keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lk_valid | input | 1 | Lookup request |
| lk_key | input | 8 | Key to search for |
| lk_mode | input | 1 | 0 = first-hit, 1 = all-hits |
| wr_en | input | 1 | Write a slot |
| wr_idx | input | 4 | Slot to write |
| wr_data | input | 8 | Word to store |
| clr_en | input | 1 | Invalidate request |
| clr_all | input | 1 | With clr_en: invalidate every slot |
| clr_idx | input | 4 | With clr_en and not clr_all: slot to invalidate |
| res_valid | output | 1 | Lookup result present |
| res_hit | output | 1 | At least one slot matched |
| res_idx | output | 4 | Lowest matching slot |
| res_vec | output | 16 | Match bitmap (one-hot in first-hit mode) |
| res_count | output | 5 | Number of bits set in res_vec |

## Verification
The hardest case to reach from the ports is a lookup racing an update of the very slot it is searching. Both the old-word hit and the new-word miss must then be seen in that cycle, and the reverse must be seen on the next cycle. The bench drives a write and a lookup on the same clock edge and then repeats the lookup with both the old and the new key. The same approach drives a simultaneous write and invalidation of one slot. It also covers a slot that is invalidated while its word is left in place, which is then searched for with that exact word.

// File: rtl/cam_pkg.sv
package cam_pkg;
  typedef enum logic {
    CAM_MODE_FIRST = 1'b0,
    CAM_MODE_ALL   = 1'b1
  } cam_mode_e;
endpackage

// File: rtl/cam_entry_store.sv
module cam_entry_store #(
  parameter int ENTRIES = 16,
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [IDX_W-1:0]            wr_idx,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic                        clr_en,
  input  logic                        clr_all,
  input  logic [IDX_W-1:0]            clr_idx,
  output logic [ENTRIES*DATA_W-1:0]   entry_data,
  output logic [ENTRIES-1:0]          entry_valid
);
  logic [ENTRIES-1:0] wr_sel;
  logic [ENTRIES-1:0] clr_sel;
  logic [ENTRIES-1:0] valid_d, valid_q;

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_slot
    logic [DATA_W-1:0] word_q;

    assign wr_sel[gi]  = wr_en && (wr_idx == IDX_W'(gi));
    assign clr_sel[gi] = clr_en && (clr_all || (clr_idx == IDX_W'(gi)));

    // storage word: only loaded by a write, never reset
    always_ff @(posedge clk) begin
      if (wr_sel[gi]) begin
        word_q <= wr_data;
      end
    end

    assign entry_data[gi*DATA_W +: DATA_W] = word_q;
  end

  // a write to a slot overrides an invalidation of the same slot
  always_comb begin
    valid_d = (valid_q & ~clr_sel) | wr_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (wr_en || clr_en) begin
      valid_q <= valid_d;
    end
  end

  assign entry_valid = valid_q;
endmodule

// File: rtl/cam_match_array.sv
module cam_match_array #(
  parameter int ENTRIES = 16,
  parameter int DATA_W  = 8
) (
  input  logic [DATA_W-1:0]         key,
  input  logic [ENTRIES*DATA_W-1:0] entry_data,
  input  logic [ENTRIES-1:0]        entry_valid,
  output logic [ENTRIES-1:0]        match_vec
);
  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_cmp
    assign match_vec[gi] = entry_valid[gi] &&
                           (entry_data[gi*DATA_W +: DATA_W] == key);
  end
endmodule

// File: rtl/cam_prio_encoder.sv
module cam_prio_encoder #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx,
  output logic [N-1:0]     grant
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        grant = N'(1) << i;
      end
    end
  end
endmodule

// File: rtl/cam_pop_count.sv
module cam_pop_count #(
  parameter int N     = 16,
  parameter int CNT_W = 5
) (
  input  logic [N-1:0]     vec,
  output logic [CNT_W-1:0] cnt
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) begin
      cnt = cnt + CNT_W'(vec[i]);
    end
  end
endmodule

// File: rtl/cam_lookup_unit.sv
module cam_lookup_unit #(
  parameter int ENTRIES = 16,
  parameter int DATA_W  = 8,
  parameter int IDX_W   = $clog2(ENTRIES),
  parameter int CNT_W   = $clog2(ENTRIES + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  input  logic [DATA_W-1:0]  lk_key,
  input  logic               lk_mode,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               clr_en,
  input  logic               clr_all,
  input  logic [IDX_W-1:0]   clr_idx,
  output logic               res_valid,
  output logic               res_hit,
  output logic [IDX_W-1:0]   res_idx,
  output logic [ENTRIES-1:0] res_vec,
  output logic [CNT_W-1:0]   res_count
);
  import cam_pkg::*;

  localparam int SYNC_STAGES = 2;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_STAGES-1:0] rst_pipe_q;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[SYNC_STAGES-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[SYNC_STAGES-1];

  logic [ENTRIES*DATA_W-1:0] entry_data;
  logic [ENTRIES-1:0]        entry_valid;
  logic [ENTRIES-1:0]        match_vec;
  logic [ENTRIES-1:0]        first_vec;
  logic [ENTRIES-1:0]        sel_vec;
  logic                      any_hit;
  logic [IDX_W-1:0]          first_idx;
  logic [CNT_W-1:0]          sel_count;
  cam_mode_e                 mode_sel;

  cam_entry_store #(
    .ENTRIES(ENTRIES), .DATA_W(DATA_W), .IDX_W(IDX_W)
  ) u_store (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .clr_en     (clr_en),
    .clr_all    (clr_all),
    .clr_idx    (clr_idx),
    .entry_data (entry_data),
    .entry_valid(entry_valid)
  );

  cam_match_array #(
    .ENTRIES(ENTRIES), .DATA_W(DATA_W)
  ) u_match (
    .key        (lk_key),
    .entry_data (entry_data),
    .entry_valid(entry_valid),
    .match_vec  (match_vec)
  );

  cam_prio_encoder #(
    .N(ENTRIES), .IDX_W(IDX_W)
  ) u_prio (
    .req  (match_vec),
    .found(any_hit),
    .idx  (first_idx),
    .grant(first_vec)
  );

  assign mode_sel = cam_mode_e'(lk_mode);
  assign sel_vec  = (mode_sel == CAM_MODE_ALL) ? match_vec : first_vec;

  cam_pop_count #(
    .N(ENTRIES), .CNT_W(CNT_W)
  ) u_count (
    .vec(sel_vec),
    .cnt(sel_count)
  );

  // result stage: next-state and register kept apart
  logic               valid_d;
  logic               hit_d;
  logic [IDX_W-1:0]   idx_d;
  logic [ENTRIES-1:0] vec_d;
  logic [CNT_W-1:0]   count_d;
  logic               res_load;

  assign res_load = lk_valid;

  always_comb begin
    valid_d = lk_valid;
    hit_d   = any_hit;
    idx_d   = first_idx;
    vec_d   = sel_vec;
    count_d = sel_count;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_valid <= 1'b0;
    end else begin
      res_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_hit   <= 1'b0;
      res_idx   <= '0;
      res_vec   <= '0;
      res_count <= '0;
    end else if (res_load) begin
      res_hit   <= hit_d;
      res_idx   <= idx_d;
      res_vec   <= vec_d;
      res_count <= count_d;
    end
  end
endmodule

// File: rtl/cam_lookup_unit_chk.sv
module cam_lookup_unit_chk #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = 4,
  parameter int CNT_W   = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               lk_mode,
  input logic               wr_en,
  input logic               clr_en,
  input logic               clr_all,
  input logic               res_valid,
  input logic               res_hit,
  input logic [IDX_W-1:0]   res_idx,
  input logic [ENTRIES-1:0] res_vec,
  input logic [CNT_W-1:0]   res_count
);
  // R3
  res_valid_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == $past(lk_valid));

  // R4
  first_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !$past(lk_mode)) |-> ($countones(res_vec) == int'(res_hit)));

  // R5
  count_matches_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (int'(res_count) == $countones(res_vec)));

  // R6
  miss_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_vec == '0 && res_idx == '0));

  // R9
  clear_all_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(clr_en && clr_all && !wr_en, 2)) |-> !res_hit);

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(lk_valid) |-> ($stable(res_vec) && $stable(res_idx) && $stable(res_count)));
endmodule

bind cam_lookup_unit cam_lookup_unit_chk #(
  .ENTRIES(ENTRIES), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .lk_valid (lk_valid),
  .lk_mode  (lk_mode),
  .wr_en    (wr_en),
  .clr_en   (clr_en),
  .clr_all  (clr_all),
  .res_valid(res_valid),
  .res_hit  (res_hit),
  .res_idx  (res_idx),
  .res_vec  (res_vec),
  .res_count(res_count)
);

// File: tb/cam_lookup_unit_tb.sv
module cam_lookup_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic        clk;
  logic        rst_n;
  logic        lk_valid;
  logic [7:0]  lk_key;
  logic        lk_mode;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [7:0]  wr_data;
  logic        clr_en;
  logic        clr_all;
  logic [3:0]  clr_idx;
  logic        res_valid;
  logic        res_hit;
  logic [3:0]  res_idx;
  logic [15:0] res_vec;
  logic [4:0]  res_count;

  int checks = 0;
  int fails  = 0;
  logic [7:0] m_data [N];
  logic       m_valid[N];

  cam_lookup_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(lk_valid), .lk_key(lk_key), .lk_mode(lk_mode),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .clr_en(clr_en), .clr_all(clr_all), .clr_idx(clr_idx),
    .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx),
    .res_vec(res_vec), .res_count(res_count)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
    check(act == exp, req, what, act, exp);
  endtask

  task automatic wr_slot(input int idx, input logic [7:0] d);
    wr_en = 1'b1; wr_idx = 4'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    m_data[idx] = d; m_valid[idx] = 1'b1;
  endtask

  task automatic clr_slot(input bit all, input int idx);
    clr_en = 1'b1; clr_all = all; clr_idx = 4'(idx);
    @(negedge clk);
    clr_en = 1'b0; clr_all = 1'b0;
    for (int i = 0; i < N; i++) if (all || i == idx) m_valid[i] = 1'b0;
  endtask

  // expected result from the model as it stands before this cycle's edge
  task automatic look(input logic [7:0] key, input bit mode, input string req);
    logic [15:0] all_v, exp_v;
    logic [3:0]  exp_i;
    int          exp_c;
    all_v = '0; exp_i = '0;
    for (int i = 0; i < N; i++) if (m_valid[i] && m_data[i] == key) all_v[i] = 1'b1;
    for (int i = N - 1; i >= 0; i--) if (all_v[i]) exp_i = 4'(i);
    exp_v = mode ? all_v : ((all_v != 0) ? (16'd1 << exp_i) : 16'd0);
    exp_c = $countones(exp_v);
    lk_valid = 1'b1; lk_key = key; lk_mode = mode;
    @(negedge clk);
    lk_valid = 1'b0;
    check_eq(req, "res_valid", 32'(res_valid), 32'd1);
    check_eq(req, "res_hit",   32'(res_hit),   32'(all_v != 0));
    check_eq(req, "res_idx",   32'(res_idx),   32'(exp_i));
    check_eq(req, "res_vec",   32'(res_vec),   32'(exp_v));
    check_eq(req, "res_count", 32'(res_count), 32'(exp_c));
  endtask

  task automatic t_reset();
    check_eq("R1", "reset res_valid", 32'(res_valid), 32'd0);
    check_eq("R1", "reset res_hit",   32'(res_hit),   32'd0);
    check_eq("R1", "reset res_vec",   32'(res_vec),   32'd0);
    check_eq("R1", "reset res_count", 32'(res_count), 32'd0);
    look(8'h00, 1'b1, "R1");
    look(8'hFF, 1'b0, "R1");
  endtask

  task automatic t_first_hit();
    wr_slot(3, 8'h5A); wr_slot(7, 8'h5A); wr_slot(10, 8'h11); wr_slot(15, 8'hC3);
    look(8'h5A, 1'b0, "R2_R4");
    look(8'h11, 1'b0, "R2_R4");
    look(8'hC3, 1'b0, "R4");   // highest slot
  endtask

  task automatic t_all_hits();
    look(8'h5A, 1'b1, "R5");
    for (int i = 0; i < N; i++) wr_slot(i, 8'hE7);
    look(8'hE7, 1'b1, "R5");   // all sixteen slots
    check_eq("R5", "full count", 32'(res_count), 32'd16);
    look(8'hE7, 1'b0, "R4");
    check_eq("R4", "first of full", 32'(res_idx), 32'd0);
  endtask

  task automatic t_miss();
    look(8'h42, 1'b0, "R6");
    look(8'h42, 1'b1, "R6");
  endtask

  task automatic t_clear_one();
    wr_slot(2, 8'h77); wr_slot(9, 8'h77);
    clr_slot(1'b0, 2);
    look(8'h77, 1'b0, "R8");
    check_eq("R8", "next slot wins", 32'(res_idx), 32'd9);
    look(8'h77, 1'b1, "R7_R8");
    check_eq("R7", "cleared slot absent", 32'(res_vec), 32'h0200);
  endtask

  task automatic t_clear_all();
    clr_slot(1'b1, 0);
    look(8'hE7, 1'b1, "R9");
    look(8'h77, 1'b0, "R9");
    look(8'h00, 1'b1, "R7_R9");
  endtask

  task automatic t_same_cycle();
    wr_slot(5, 8'h22);
    wr_en = 1'b1; wr_idx = 4'd5; wr_data = 8'h33;
    look(8'h22, 1'b0, "R10");   // sees old word
    check_eq("R10", "old word hit", 32'(res_hit), 32'd1);
    wr_en = 1'b0;
    m_data[5] = 8'h33;
    look(8'h22, 1'b0, "R10");
    check_eq("R10", "old word gone", 32'(res_hit), 32'd0);
    look(8'h33, 1'b0, "R10");
    check_eq("R10", "new word idx", 32'(res_idx), 32'd5);
  endtask

  task automatic t_write_vs_clear();
    wr_en = 1'b1; wr_idx = 4'd12; wr_data = 8'h9C;
    clr_en = 1'b1; clr_all = 1'b0; clr_idx = 4'd12;
    @(negedge clk);
    wr_en = 1'b0; clr_en = 1'b0;
    m_data[12] = 8'h9C; m_valid[12] = 1'b1;
    look(8'h9C, 1'b0, "R11");
    check_eq("R11", "write wins", 32'(res_hit), 32'd1);
  endtask

  task automatic t_hold();
    logic [15:0] v; logic [3:0] ix; logic [4:0] c; logic h;
    look(8'h33, 1'b1, "R12");
    v = res_vec; ix = res_idx; c = res_count; h = res_hit;
    for (int k = 0; k < 3; k++) begin
      lk_key = 8'h9C; lk_mode = 1'b0;
      @(negedge clk);
      check_eq("R3", "idle res_valid", 32'(res_valid), 32'd0);
      check_eq("R12", "held vec", 32'(res_vec), 32'(v));
      check_eq("R12", "held idx", 32'(res_idx), 32'(ix));
      check_eq("R12", "held count", 32'(res_count), 32'(c));
      check_eq("R12", "held hit", 32'(res_hit), 32'(h));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lk_valid = 1'b0; lk_key = '0; lk_mode = 1'b0;
    wr_en = 1'b0; wr_idx = '0; wr_data = '0;
    clr_en = 1'b0; clr_all = 1'b0; clr_idx = '0;
    for (int i = 0; i < N; i++) begin m_data[i] = '0; m_valid[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_first_hit();
    t_all_hits();
    t_miss();
    t_clear_one();
    t_clear_all();
    t_same_cycle();
    t_write_vs_clear();
    t_hold();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule